// File: doc/BRIEF.md
# Chip-Select Serviced Watchdog Timer

This block counts system clocks and, if the serial chip-select line stays quiet for a full time-out period, issues a one-cycle strobe asking the downstream reset pulse generator to drive both reset outputs. Host software keeps the watchdog alive simply by touching the chip-select line. Either a rising or a falling transition is enough to service it. The time-out length is a parameter given in clock cycles. Its default corresponds to 1.6 s at a 1 MHz clock.

The counter is forced to zero while the system is not yet allowed to run. This covers three cases: the supply is below its trip threshold, the power-up time-out has not yet finished, or an external reset input is asserted. The power-up time-out indication comes from the reset pulse generator, which restarts it on every reset event. Because the hold is the OR of both conditions, an external reset keeps the watchdog cleared until the later of two events: the end of that time-out or the release of the input. After a strobe the count is already back at zero. It stays there for as long as the resulting reset hold lasts.

Top module: `cs_watchdog`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `wd_expire` is 0.
- R2: With no hold condition and a steady chip-select, `wd_expire` is 1 in exactly the TIMEOUT_CYCLES-th clock cycle after the hold is released, and 0 in every cycle before it.
- R3: A 0-to-1 change of `cs_sync` restarts the count: the next strobe comes TIMEOUT_CYCLES cycles after the first clock edge that samples the new level.
- R4: A 1-to-0 change of `cs_sync` restarts the count in the same way as R3.
- R5: While `supply_low` is 1 the count is held at zero and `wd_expire` stays 0. Counting restarts from zero once it is 0 again.
- R6: While `por_done` is 0 the count is held at zero and `wd_expire` stays 0.
- R7: While `ext_rst` is 1 the count is held at zero. Counting resumes only when both `ext_rst` is 0 and `por_done` is 1, whichever of the two happens later.
- R8: After a strobe the count starts again from zero. With no hold it gives the next strobe TIMEOUT_CYCLES cycles later. With a hold following the strobe it gives the next strobe TIMEOUT_CYCLES cycles after that hold is released.
- R9: `wd_expire` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_sync | input | 1 | Chip-select already synchronized to `clk` |
| supply_low | input | 1 | 1 while the supply is below the trip threshold |
| por_done | input | 1 | 1 once the power-up reset time-out has elapsed |
| ext_rst | input | 1 | 1 while either external reset input is asserted |
| wd_expire | output | 1 | One-cycle time-out strobe to the reset pulse generator |

## Verification
The bench measures the exact cycle of each strobe relative to the release of a hold or a chip-select change. A design that counts one cycle too many or too few, or that ignores one edge direction, would strobe at the wrong cycle or only after a full extra period. It drives the external reset against the power-up indication in both orders. A design that released on the first condition to clear, rather than the later one, would strobe early. It chains strobes back to back and with a hold in between. A counter that failed to wrap, or that kept running under the hold, would miss the expected strobe cycle or emit a stretched pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WDT_HELD = 1'b0,
        WDT_RUN  = 1'b1
    } wdt_mode_e;

endpackage

// File: rtl/wdt_cs_edge.sv
module wdt_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_sync,
    output logic cs_toggle
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cs_sync;
        cs_toggle = cs_sync ^ st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdt_hold_ctrl.sv
module wdt_hold_ctrl
    import wdt_pkg::*;
(
    input  logic      supply_low,
    input  logic      por_done,
    input  logic      ext_rst,
    output wdt_mode_e mode
);

    // The generator restarts por_done on each reset event, so OR-ing the
    // external input with it yields the later of the two releases.
    always_comb begin
        if (supply_low || !por_done || ext_rst) begin
            mode = WDT_HELD;
        end else begin
            mode = WDT_RUN;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1_600_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  wdt_mode_e mode,
    input  logic      restart,
    output logic      fire
);

    localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (mode == WDT_HELD || restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST_CNT) begin
            st_d.cnt  = '0;
            st_d.fire = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));                              // R3
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WDT_HELD) |=> (st_q.cnt == '0 && !st_q.fire));     // R7
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> (st_q.cnt == '0));                            // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |=> !st_q.fire);                                  // R9

endmodule

// File: rtl/cs_watchdog.sv
module cs_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 1_600_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_sync,
    input  logic supply_low,
    input  logic por_done,
    input  logic ext_rst,
    output logic wd_expire
);

    logic      cs_toggle;
    wdt_mode_e mode;

    wdt_cs_edge i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_sync   (cs_sync),
        .cs_toggle (cs_toggle)
    );

    wdt_hold_ctrl i_hold (
        .supply_low (supply_low),
        .por_done   (por_done),
        .ext_rst    (ext_rst),
        .mode       (mode)
    );

    wdt_counter #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .restart (cs_toggle),
        .fire    (wd_expire)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !wd_expire);                                     // R1
    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !wd_expire);                                 // R5
    AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |=> !wd_expire);                                  // R6
    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> !wd_expire);                                    // R7
    AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sync != $past(cs_sync)) |=> !wd_expire);                // R4

endmodule

// File: tb/test_cs_watchdog.sv
module test_cs_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst_n, cs_sync, supply_low, por_done, ext_rst;
    logic wd_expire;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_watchdog #(.TIMEOUT_CYCLES(T)) i_cs_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_sync    (cs_sync),
        .supply_low (supply_low),
        .por_done   (por_done),
        .ext_rst    (ext_rst),
        .wd_expire  (wd_expire)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expect the first strobe on the n-th negedge from now.
    task automatic expect_strobe(input int n, input string req);
        int first = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (wd_expire && first < 0) first = i;
        end
        check(first == n, req, first, n);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wd_expire) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cs_sync = 1'b0; supply_low = 1'b1; por_done = 1'b0; ext_rst = 1'b0;
        repeat (3) @(negedge clk);
        check(wd_expire == 1'b0, "R1 in reset", wd_expire, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wd_expire == 1'b0, "R1 after reset", wd_expire, 0);
    endtask

    task automatic t_power_up;
        expect_quiet(3*T, "R5 supply low");
        supply_low = 1'b0;
        expect_quiet(2*T, "R6 power-up timeout pending");
        por_done = 1'b1;
        expect_strobe(T, "R2 first timeout");
        @(negedge clk);
        check(wd_expire == 1'b0, "R9 strobe width", wd_expire, 0);
        expect_strobe(T-1, "R8 back-to-back timeout");
    endtask

    task automatic t_cs_edges;
        repeat (T/2) @(negedge clk);
        cs_sync = 1'b1;
        expect_strobe(T+1, "R3 rising edge restart");
        repeat (T-3) @(negedge clk);
        cs_sync = 1'b0;
        expect_strobe(T+1, "R4 falling edge restart");
    endtask

    task automatic t_hold_after_strobe;
        por_done = 1'b0;
        expect_quiet(5, "R8 held after strobe");
        por_done = 1'b1;
        expect_strobe(T, "R8 restart after hold");
    endtask

    task automatic t_supply_dip;
        repeat (T-4) @(negedge clk);
        supply_low = 1'b1;
        expect_quiet(2, "R5 dip mid-count");
        supply_low = 1'b0;
        expect_strobe(T, "R5 restart after dip");
    endtask

    task automatic t_ext_longer;
        repeat (5) @(negedge clk);
        ext_rst = 1'b1;
        expect_quiet(3*T, "R7 ext held");
        ext_rst = 1'b0;
        expect_strobe(T, "R7 release by ext input");
    endtask

    task automatic t_por_longer;
        repeat (5) @(negedge clk);
        ext_rst = 1'b1;
        por_done = 1'b0;
        expect_quiet(5, "R7 ext with por pending");
        ext_rst = 1'b0;
        expect_quiet(2*T, "R7 por still pending");
        por_done = 1'b1;
        expect_strobe(T, "R7 release by power-up timeout");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_power_up();
        t_cs_edges();
        t_hold_after_strobe();
        t_supply_dip();
        t_ext_longer();
        t_por_longer();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule